// File: doc/BRIEF.md
# External Interrupt Controller, Single Context

This block collects up to 127 active-high, level-sensitive interrupt lines and turns them into one interrupt request for a single machine-mode hart context. Each line has a gateway. The gateway latches a pending bit when the line is high. Once the hart claims the interrupt, the gateway holds the line off until the hart signals completion. A combinational arbiter looks at the sources that are pending and enabled and whose priority is above the context threshold. It picks the highest priority, and breaks ties toward the lowest ID.

Software reaches the controller through a word-wide register port. There are per-source priority registers, a read-only pending array, an enable array, a threshold register, and a claim/complete register. A read of the claim/complete register returns the winning ID and closes that source's gateway. Writing the ID back reopens the gateway. ID 0 is reserved to mean "nothing", so input line n is interrupt ID n+1.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all priorities, enables, the threshold and all pending bits are zero, `irq_o` is low, and a claim read returns 0.
- R2: Input bit n raises ID n+1. The pending array is word-wide at byte offset 0x1000+4w, and bit b of word w holds ID 32w+b. The bit for ID 0 always reads 0.
- R3: The priority of ID k is at byte offset 4k for k from 1 to 127. It stores the low 3 bits of the write data, and the upper bits read as 0.
- R4: The enable array is at byte offset 0x2000+4w, with the same bit layout as the pending array. The bit for ID 0 always reads 0.
- R5: A high level on an open gateway sets the pending bit at the next clock edge. The bit stays set after the line drops, until the source is claimed.
- R6: `irq_o` is high exactly when some source is pending, is enabled, and has a priority strictly greater than the threshold. A priority of 0 never interrupts.
- R7: A read of the claim register at 0x200004 returns the eligible source with the highest priority, or the lowest ID among equal priorities. It returns 0 when no source is eligible.
- R8: A claim clears that source's pending bit, and the source cannot pend again until it is completed. A claim read that returns 0 changes no state.
- R9: Writing an enabled ID to the claim register completes it. If the line is still high, the source pends again on the cycle after.
- R10: A completion write is ignored if it names a disabled ID, ID 0, or an ID above 127.
- R11: The threshold is at byte offset 0x200000. It stores 3 bits, and the upper bits read as 0.
- R12: Read data appears on `reg_rdata_o` in the cycle after the read strobe. Reads of reserved or misaligned offsets return 0. Writes to them, and writes to the pending array, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 127 | Level interrupt lines; bit n is ID n+1 |
| reg_en_i | input | 1 | One-cycle register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 22 | Byte offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt request to the hart context |

## Verification
The assertions rest on a few assumptions about the inputs:
- The interrupt lines are synchronous to `clk`.
- Each register access is a single-cycle strobe.
- A gateway is only ever told to claim a source that is pending, which the arbiter ensures by construction.

The bench changes source lines and register strobes only on falling edges, holds each strobe for exactly one cycle, and uses aligned word offsets. Before reading the pending array, it leaves a full cycle after any change to a source line or a completion.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int ADDR_W      = 22;
    localparam int REG_W       = 32;
    localparam int PEND_BASE   = 32'h0000_1000;
    localparam int EN_BASE     = 32'h0000_2000;
    localparam int THRESH_OFS  = 32'h0020_0000;
    localparam int CLAIM_OFS   = 32'h0020_0004;
endpackage

// File: rtl/ext_irq_gateway.sv
module ext_irq_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o,
    output logic busy_o
);
    typedef struct packed {
        logic pending;
        logic busy;
    } gw_state_t;

    gw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (claim_i) begin
            st_d.pending = 1'b0;
            st_d.busy    = 1'b1;
        end else begin
            if (complete_i) st_d.busy = 1'b0;
            if (level_i && !st_q.busy) st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pending;
    assign busy_o    = st_q.busy;

    // R8
    gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !pending_o);
    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !claim_i) |=> pending_o);
    // R8
    claim_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> pending_o);
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter #(
    parameter int NUM_IDS = 128,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_IDS-1:0]                pending_i,
    input  logic [NUM_IDS-1:0]                enable_i,
    input  logic [NUM_IDS-1:0][PRIO_W-1:0]    prio_i,
    input  logic [PRIO_W-1:0]                 thresh_i,
    output logic [ID_W-1:0]                   best_id_o,
    output logic                              irq_o
);
    logic [PRIO_W-1:0] best_p;

    // Strict compare keeps the first (lowest) ID among equal priorities;
    // seeding with the threshold excludes anything at or below it.
    always_comb begin
        best_id_o = '0;
        best_p    = thresh_i;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (pending_i[i] && enable_i[i] && (prio_i[i] > best_p)) begin
                best_id_o = ID_W'(i);
                best_p    = prio_i[i];
            end
        end
    end

    assign irq_o = (best_id_o != '0);

    // R6
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pending_i[best_id_o] && enable_i[best_id_o] && (prio_i[best_id_o] > thresh_i)));
    // R6
    zero_prio_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (prio_i[best_id_o] != '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_SRC = 127,
    parameter int PRIO_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_src_i,
    input  logic                 reg_en_i,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 irq_o
);
    localparam int NUM_IDS   = NUM_SRC + 1;
    localparam int ID_W      = $clog2(NUM_IDS);
    localparam int NUM_WORDS = (NUM_IDS + 31) / 32;
    localparam int ARR_W     = NUM_WORDS * 32;
    localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int WA_W      = ADDR_W - 2;

    localparam logic [WA_W-1:0] PRIO_WEND = WA_W'(NUM_IDS);
    localparam logic [WA_W-1:0] PEND_W0   = WA_W'(PEND_BASE >> 2);
    localparam logic [WA_W-1:0] PEND_WEND = WA_W'((PEND_BASE >> 2) + NUM_WORDS);
    localparam logic [WA_W-1:0] EN_W0     = WA_W'(EN_BASE >> 2);
    localparam logic [WA_W-1:0] EN_WEND   = WA_W'((EN_BASE >> 2) + NUM_WORDS);
    localparam logic [WA_W-1:0] THR_W     = WA_W'(THRESH_OFS >> 2);
    localparam logic [WA_W-1:0] CLM_W     = WA_W'(CLAIM_OFS >> 2);

    typedef struct packed {
        logic [NUM_IDS-1:0][PRIO_W-1:0] prio;
        logic [NUM_IDS-1:0]             enable;
        logic [PRIO_W-1:0]              thresh;
        logic [REG_W-1:0]               rdata;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [NUM_IDS-1:0] pending_vec;
    logic [NUM_SRC-1:0] busy_src;
    logic [NUM_SRC-1:0] claim_src;
    logic [NUM_SRC-1:0] cmp_src;
    logic [ID_W-1:0]    best_id;
    logic               arb_irq;

    // ---------------- address decode ----------------
    logic [WA_W-1:0]  word_addr;
    logic [SEL_W-1:0] sel;
    logic             aligned, hit_prio, hit_pend, hit_en, hit_thr, hit_clm;
    logic             rd_stb, wr_stb;

    assign word_addr = reg_addr_i[ADDR_W-1:2];
    assign sel       = word_addr[SEL_W-1:0];
    assign aligned   = (reg_addr_i[1:0] == 2'b00);
    assign hit_prio  = aligned && (word_addr != '0) && (word_addr < PRIO_WEND);
    assign hit_pend  = aligned && (word_addr >= PEND_W0) && (word_addr < PEND_WEND);
    assign hit_en    = aligned && (word_addr >= EN_W0) && (word_addr < EN_WEND);
    assign hit_thr   = aligned && (word_addr == THR_W);
    assign hit_clm   = aligned && (word_addr == CLM_W);
    assign rd_stb    = reg_en_i && !reg_we_i;
    assign wr_stb    = reg_en_i && reg_we_i;

    // ---------------- claim / complete ----------------
    logic            claim_hit;
    logic            cmp_wr, cmp_ok;
    logic [ID_W-1:0] cmp_id;

    assign claim_hit = rd_stb && hit_clm && (best_id != '0);
    assign cmp_wr    = wr_stb && hit_clm;
    assign cmp_id    = reg_wdata_i[ID_W-1:0];
    assign cmp_ok    = cmp_wr
                    && (reg_wdata_i[REG_W-1:ID_W] == '0)
                    && (cmp_id != '0)
                    && ({1'b0, cmp_id} < (ID_W+1)'(NUM_IDS))
                    && st_q.enable[cmp_id];

    // ---------------- per-source gateways ----------------
    assign pending_vec[0] = 1'b0;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign claim_src[s] = claim_hit && (best_id == ID_W'(s + 1));
        assign cmp_src[s]   = cmp_ok && (cmp_id == ID_W'(s + 1));

        ext_irq_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_i    (irq_src_i[s]),
            .claim_i    (claim_src[s]),
            .complete_i (cmp_src[s]),
            .pending_o  (pending_vec[s + 1]),
            .busy_o     (busy_src[s])
        );
    end

    // ---------------- arbitration ----------------
    ext_irq_arbiter #(
        .NUM_IDS (NUM_IDS),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending_vec),
        .enable_i  (st_q.enable),
        .prio_i    (st_q.prio),
        .thresh_i  (st_q.thresh),
        .best_id_o (best_id),
        .irq_o     (arb_irq)
    );

    // ---------------- register file ----------------
    logic [ARR_W-1:0] pend_arr, en_arr;
    assign pend_arr = ARR_W'(pending_vec);
    assign en_arr   = ARR_W'(st_q.enable);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_stb) begin
            if (hit_prio) st_d.prio[word_addr[ID_W-1:0]] = reg_wdata_i[PRIO_W-1:0];
            if (hit_thr)  st_d.thresh = reg_wdata_i[PRIO_W-1:0];
            if (hit_en) begin
                for (int b = 0; b < 32; b++) begin
                    if (((int'(sel) * 32 + b) >= 1) && ((int'(sel) * 32 + b) < NUM_IDS))
                        st_d.enable[int'(sel) * 32 + b] = reg_wdata_i[b];
                end
            end
        end
        if (rd_stb) begin
            if (hit_prio)      st_d.rdata = REG_W'(st_q.prio[word_addr[ID_W-1:0]]);
            else if (hit_pend) st_d.rdata = pend_arr[{sel, 5'b00000} +: 32];
            else if (hit_en)   st_d.rdata = en_arr[{sel, 5'b00000} +: 32];
            else if (hit_thr)  st_d.rdata = REG_W'(st_q.thresh);
            else if (hit_clm)  st_d.rdata = REG_W'(best_id);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata_o = st_q.rdata;
    assign irq_o       = arb_irq;

    // R8
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit |=> !pending_vec[$past(best_id)]);
    // R10
    ignored_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !cmp_ok) |=> $stable(busy_src));
    // R12
    reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(hit_prio || hit_pend || hit_en || hit_thr || hit_clm)) |=> (reg_rdata_o == '0));
    // R1
    id_zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.enable[0] && (st_q.prio[0] == '0));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
    localparam int NS = 127;
    localparam logic [21:0] THR_A = 22'h20_0000;
    localparam logic [21:0] CLM_A = 22'h20_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [21:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src),
        .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [21:0] a, logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(logic [21:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [21:0] pa(int id);  return 22'(id * 4); endfunction
    function automatic logic [21:0] pw(int w);   return 22'(32'h1000 + 4 * w); endfunction
    function automatic logic [21:0] ew(int w);   return 22'(32'h2000 + 4 * w); endfunction
    function automatic logic [31:0] bitof(int id); return 32'(1) << (id % 32); endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("[TB] FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        rd(CLM_A, d); check("R1 claim", d, 0);
        rd(THR_A, d); check("R1 thresh", d, 0);
        for (int w = 0; w < 4; w++) begin
            rd(pw(w), d); check("R1 pend", d, 0);
            rd(ew(w), d); check("R1 en", d, 0);
        end
        rd(pa(1), d); check("R1 prio1", d, 0);
        rd(pa(127), d); check("R1 prio127", d, 0);

        // R3 priority registers, 3 bits stored
        for (int id = 1; id <= NS; id++) wr(pa(id), 32'hFFFF_FFF8 | 32'((id * 3 + 1) % 8));
        for (int id = 1; id <= NS; id++) begin
            rd(pa(id), d); check("R3 prio", d, 32'((id * 3 + 1) % 8));
        end
        // R12 reserved offset 0
        wr(22'h0, 32'h7); rd(22'h0, d); check("R12 ofs0", d, 0);

        // R4 enable array layout
        for (int w = 0; w < 4; w++) wr(ew(w), 32'hFFFF_FFFF);
        for (int w = 0; w < 4; w++) begin
            rd(ew(w), d); check("R4 en", d, (w == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF);
        end

        // R11 threshold width
        wr(THR_A, 32'hFFFF_FFFF); rd(THR_A, d); check("R11 thresh", d, 7);
        wr(THR_A, 0);

        for (int id = 1; id <= NS; id++) wr(pa(id), 1);

        // R2 R5 R7 R8 R9 sweep over every line
        for (int n = 0; n < NS; n++) begin
            src[n] = 1'b1; tick(); tick();
            rd(pw((n + 1) / 32), d); check("R2 pend map", d, bitof(n + 1));
            check("R6 irq on", 32'(irq), 1);
            rd(CLM_A, d); check("R7 claim id", d, 32'(n + 1));
            rd(pw((n + 1) / 32), d); check("R8 blocked", d, 0);
            src[n] = 1'b0;
            wr(CLM_A, 32'(n + 1)); tick(); tick();
            rd(pw((n + 1) / 32), d); check("R9 low no repend", d, 0);
            check("R6 irq off", 32'(irq), 0);
        end

        // R7 arbitration order, ties to lowest ID
        wr(pa(10), 3); wr(pa(50), 6); wr(pa(90), 6); wr(pa(120), 2);
        src[9] = 1; src[49] = 1; src[89] = 1; src[119] = 1;
        tick(); tick();
        src[119] = 0; tick(); tick();
        rd(pw(3), d); check("R5 latched", d, bitof(120));
        rd(CLM_A, d); check("R7 first", d, 50);
        rd(pw(1), d); check("R8 50 held", d, 0);
        rd(CLM_A, d); check("R7 tie", d, 90);
        rd(CLM_A, d); check("R7 third", d, 10);
        rd(CLM_A, d); check("R7 fourth", d, 120);
        wr(CLM_A, 50); tick(); tick();
        rd(pw(1), d); check("R9 repend", d, bitof(50));
        rd(CLM_A, d); check("R7 again", d, 50);
        rd(CLM_A, d); check("R7 none", d, 0);
        src[9] = 0; src[49] = 0; src[89] = 0;
        wr(CLM_A, 10); wr(CLM_A, 50); wr(CLM_A, 90); wr(CLM_A, 120);
        tick(); tick();

        // R6 exhaustive priority vs threshold on ID 5
        src[4] = 1; tick(); tick();
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 8; t++) begin
                wr(pa(5), 32'(p)); wr(THR_A, 32'(t));
                check("R6 irq vs thresh", 32'(irq), (p > t) ? 1 : 0);
                rd(CLM_A, d); check("R7 claim vs thresh", d, (p > t) ? 5 : 0);
                if (p > t) begin
                    wr(CLM_A, 5); tick(); tick();
                end else begin
                    rd(pw(0), d); check("R8 null claim", d, bitof(5));
                end
            end
        end
        src[4] = 0;
        wr(THR_A, 0); wr(pa(5), 7);
        rd(CLM_A, d); check("R7 drain", d, 5);
        wr(CLM_A, 5); tick(); tick();

        // R6 R10 enables and ignored completions
        wr(pa(20), 4);
        wr(ew(0), 0);
        src[19] = 1; tick(); tick();
        check("R6 disabled", 32'(irq), 0);
        rd(pw(0), d); check("R6 pend visible", d, bitof(20));
        rd(CLM_A, d); check("R7 disabled", d, 0);
        wr(ew(0), 32'hFFFF_FFFF);
        check("R6 enabled", 32'(irq), 1);
        rd(CLM_A, d); check("R7 id20", d, 20);
        wr(ew(0), 0);
        wr(CLM_A, 20); tick(); tick();
        rd(pw(0), d); check("R10 disabled id", d, 0);
        wr(ew(0), 32'hFFFF_FFFF);
        wr(CLM_A, 0); wr(CLM_A, 200); wr(CLM_A, 32'h1_0014); tick(); tick();
        rd(pw(0), d); check("R10 bad id", d, 0);
        wr(CLM_A, 20); tick(); tick();
        rd(pw(0), d); check("R9 complete", d, bitof(20));
        src[19] = 0;
        rd(CLM_A, d); check("R7 id20 again", d, 20);
        wr(CLM_A, 20); tick(); tick();

        // R12 reserved offsets and read-only pending
        rd(22'h1010, d); check("R12 1010", d, 0);
        rd(22'h0204, d); check("R12 0204", d, 0);
        rd(22'h20_0008, d); check("R12 200008", d, 0);
        rd(22'h3000, d); check("R12 3000", d, 0);
        wr(pw(0), 32'hFFFF_FFFF); tick();
        rd(pw(0), d); check("R12 pend ro", d, 0);
        check("R12 irq", 32'(irq), 0);

        finish_run();
    end
endmodule